// File: doc/BRIEF.md
# Divider-Switching Bit Clock Recovery

This block recovers the bit-cell timing of a self-clocked serial line (biphase-mark or differential-Manchester style coding) from a local oversampling clock. A period counter normally divides the local clock by `DIV_NOM` and emits one strobe per recovered bit cell. The line's own transitions serve as the phase reference. Cell-boundary transitions that arrive a little late stretch the current period by one clock. Transitions that arrive a little early shrink the next period by one clock. Apart from these single-period adjustments the division stays at its nominal value.

Transitions near the middle of a cell are the extra mid-cell changes that coded ones carry, so they are ignored. A lock flag tracks whether corrections are occasional, as they should be between two nominally matched clocks. It falls when the loop has to correct period after period in one direction, which means the two clocks are far apart. The early and late pulses show which way each correction went. The block is meant to feed a frame decoder that samples data at the recovered strobe.

Top module: `cell_clock_recover`

## Requirements
- R1: While `rst` is high, every output is low. `bit_strobe_o` is first high in the `DIV_NOM`-th cycle after the last rising edge at which `rst` is sampled high, with the cycle that edge starts counting as the first.
- R2: With no correction pending, `bit_strobe_o` is high for exactly one cycle every `DIV_NOM` cycles. The count inside a period runs from 0, in the cycle after a strobe, up to the strobe cycle.
- R3: `line_i` passes through `SYNC_LEN` synchronising flops plus one history flop. A change made between two rising edges is detected in the cycle that starts at the `SYNC_LEN`-th rising edge after it. A transition detected at count 0 is on time and causes no pulse.
- R4: A transition detected at count 1 to `DIV_NOM/4` is late. `late_o` is high in that cycle, and the current period lasts `DIV_NOM+1` cycles.
- R5: A transition detected at count `DIV_NOM-DIV_NOM/4` to `DIV_NOM-1` is early. `early_o` is high in that cycle, and the following period lasts `DIV_NOM-1` cycles.
- R6: At most one of `early_o`/`late_o` pulses within a period. A period already shortened by an early correction is never lengthened.
- R7: Transitions detected at counts `DIV_NOM/4+1` to `DIV_NOM-DIV_NOM/4-1` (the mid-cell zone) produce no pulse and do not change the period length.
- R8: `locked_o` rises after `LOCK_COUNT` consecutive periods that each contain at least one detected transition and no correction. A period is judged in its strobe cycle, and the flag changes one cycle after that.
- R9: `locked_o` falls after `UNLOCK_COUNT` consecutive periods that are each corrected in the same direction. An uncorrected period, or a change of direction, restarts that run, so isolated corrections keep the lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Serial line, asynchronous to `clk` |
| bit_strobe_o | output | 1 | One-cycle pulse closing each recovered bit period |
| locked_o | output | 1 | High while corrections stay occasional |
| early_o | output | 1 | Pulse: an early transition was seen, next period shortened |
| late_o | output | 1 | Pulse: a late transition was seen, current period lengthened |

## Verification
The bench aligns a coded stream with mixed ones and zeros to the strobe, so every mid-cell transition lands in the ignored zone. This shows that on-time edges and mid-cell edges leave the division at 8, and that the lock builds up. Single cells of 7 and 9 clocks tell an early step apart from a late step by the pulse direction and by whether the shortened interval appears in this period or the next. A three-count step into the mid-cell zone, and its return, must cause no pulse at all. Runs of 7-clock and 9-clock cells model a fast and a slow source, which must correct every period and drop the lock after the fourth correction, while alternating isolated steps must not.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    typedef enum logic {
        DIR_EARLY = 1'b0,
        DIR_LATE  = 1'b1
    } corr_dir_e;

    // Summary of one recovered bit period, valid in its strobe cycle.
    typedef struct packed {
        logic      done;
        logic      seen_edge;
        logic      corrected;
        corr_dir_e dir;
    } period_stat_t;

    function automatic logic in_range(input int unsigned v, input int unsigned lo,
                                      input int unsigned hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/ccr_line_edge.sv
module ccr_line_edge #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic edge_o
);
    logic [SYNC_LEN-1:0] sync_q;
    logic                hist_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= line_i;
    end

    for (genvar g = 1; g < SYNC_LEN; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) sync_q[g] <= 1'b0;
            else     sync_q[g] <= sync_q[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= 1'b0;
        else     hist_q <= sync_q[SYNC_LEN-1];
    end

    assign edge_o = sync_q[SYNC_LEN-1] ^ hist_q;

endmodule

// File: rtl/ccr_phase_div.sv
module ccr_phase_div
    import ccr_pkg::*;
#(
    parameter int DIV_NOM = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         edge_i,
    output logic         strobe_o,
    output logic         early_o,
    output logic         late_o,
    output period_stat_t stat_o
);
    localparam int CW  = $clog2(DIV_NOM + 1);
    localparam int WIN = DIV_NOM / 4;
    localparam logic [CW-1:0] TC_NOM   = CW'(DIV_NOM - 1);
    localparam logic [CW-1:0] TC_SHORT = CW'(DIV_NOM - 2);
    localparam logic [CW-1:0] TC_LONG  = CW'(DIV_NOM);

    logic [CW-1:0] cnt_q, tc_q;
    logic          decided_q, altered_q, arm_short_q, edge_seen_q;
    corr_dir_e     dir_q;
    logic          wrap, late_fire, early_fire;

    assign wrap       = (cnt_q == tc_q);
    assign late_fire  = edge_i && !decided_q && !altered_q
                        && in_range(int'(cnt_q), 1, WIN);
    assign early_fire = edge_i && !decided_q
                        && in_range(int'(cnt_q), DIV_NOM - WIN, DIV_NOM - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            tc_q        <= TC_NOM;
            decided_q   <= 1'b0;
            altered_q   <= 1'b0;
            arm_short_q <= 1'b0;
            edge_seen_q <= 1'b0;
            dir_q       <= DIR_EARLY;
        end else if (wrap) begin
            cnt_q       <= '0;
            tc_q        <= (arm_short_q || early_fire) ? TC_SHORT : TC_NOM;
            altered_q   <= arm_short_q || early_fire;
            decided_q   <= 1'b0;
            arm_short_q <= 1'b0;
            edge_seen_q <= 1'b0;
            if (early_fire) dir_q <= DIR_EARLY;
        end else begin
            cnt_q       <= cnt_q + 1'b1;
            edge_seen_q <= edge_seen_q || edge_i;
            if (late_fire) begin
                tc_q      <= TC_LONG;
                altered_q <= 1'b1;
                decided_q <= 1'b1;
                dir_q     <= DIR_LATE;
            end
            if (early_fire) begin
                arm_short_q <= 1'b1;
                decided_q   <= 1'b1;
                dir_q       <= DIR_EARLY;
            end
        end
    end

    assign strobe_o = wrap;
    assign early_o  = early_fire;
    assign late_o   = late_fire;

    always_comb begin
        stat_o.done      = wrap;
        stat_o.seen_edge = edge_seen_q || edge_i;
        stat_o.corrected = decided_q || early_fire;
        stat_o.dir       = early_fire ? DIR_EARLY : dir_q;
    end

    a_r2_wrap_restart: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt_q == '0));
    a_r2_len_range: assert property (@(posedge clk) disable iff (rst)
        (tc_q >= TC_SHORT) && (tc_q <= TC_LONG));
    a_r4_late_stretch: assert property (@(posedge clk) disable iff (rst)
        late_fire |=> (tc_q == TC_LONG) && !strobe_o);
    a_r5_early_shrink: assert property (@(posedge clk) disable iff (rst)
        (early_fire && wrap) |=> (tc_q == TC_SHORT));
    a_r6_one_per_period: assert property (@(posedge clk) disable iff (rst)
        (early_fire || late_fire) |=> !(early_fire || late_fire));
    a_r6_no_stretch_after_shrink: assert property (@(posedge clk) disable iff (rst)
        (tc_q == TC_SHORT) |-> !late_fire);

endmodule

// File: rtl/ccr_lock_mon.sv
module ccr_lock_mon
    import ccr_pkg::*;
#(
    parameter int LOCK_RUN   = 16,
    parameter int UNLOCK_RUN = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  period_stat_t stat_i,
    output logic         locked_o
);
    localparam int CLW = $clog2(LOCK_RUN + 1);
    localparam int ULW = $clog2(UNLOCK_RUN + 1);
    localparam logic [CLW-1:0] CLEAN_MAX = CLW'(LOCK_RUN);
    localparam logic [ULW-1:0] RUN_MAX   = ULW'(UNLOCK_RUN);

    logic [CLW-1:0] clean_q, clean_n;
    logic [ULW-1:0] run_q, run_n;
    corr_dir_e      dir_q, dir_n;
    logic           locked_q, lock_n;

    always_comb begin
        clean_n = clean_q;
        run_n   = run_q;
        dir_n   = dir_q;
        lock_n  = locked_q;
        if (stat_i.done) begin
            if (stat_i.corrected) begin
                clean_n = '0;
                if (run_q != '0 && stat_i.dir == dir_q)
                    run_n = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
                else
                    run_n = ULW'(1);
                dir_n = stat_i.dir;
                if (run_n == RUN_MAX) lock_n = 1'b0;
            end else if (stat_i.seen_edge) begin
                run_n   = '0;
                clean_n = (clean_q == CLEAN_MAX) ? clean_q : clean_q + 1'b1;
                if (clean_n == CLEAN_MAX) lock_n = 1'b1;
            end else begin
                run_n   = '0;
                clean_n = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clean_q  <= '0;
            run_q    <= '0;
            dir_q    <= DIR_EARLY;
            locked_q <= 1'b0;
        end else begin
            clean_q  <= clean_n;
            run_q    <= run_n;
            dir_q    <= dir_n;
            locked_q <= lock_n;
        end
    end

    assign locked_o = locked_q;

    a_r8_lock_needs_clean: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_q) |-> $past(stat_i.done && stat_i.seen_edge && !stat_i.corrected));
    a_r9_unlock_needs_corr: assert property (@(posedge clk) disable iff (rst)
        $fell(locked_q) |-> $past(stat_i.done && stat_i.corrected));

endmodule

// File: rtl/cell_clock_recover.sv
module cell_clock_recover
    import ccr_pkg::*;
#(
    parameter int DIV_NOM      = 8,
    parameter int SYNC_LEN     = 2,
    parameter int LOCK_COUNT   = 16,
    parameter int UNLOCK_COUNT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic bit_strobe_o,
    output logic locked_o,
    output logic early_o,
    output logic late_o
);
    logic         line_edge;
    period_stat_t stat;

    ccr_line_edge #(.SYNC_LEN(SYNC_LEN)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_i),
        .edge_o (line_edge)
    );

    ccr_phase_div #(.DIV_NOM(DIV_NOM)) u_div (
        .clk      (clk),
        .rst      (rst),
        .edge_i   (line_edge),
        .strobe_o (bit_strobe_o),
        .early_o  (early_o),
        .late_o   (late_o),
        .stat_o   (stat)
    );

    ccr_lock_mon #(.LOCK_RUN(LOCK_COUNT), .UNLOCK_RUN(UNLOCK_COUNT)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .stat_i   (stat),
        .locked_o (locked_o)
    );

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        $past(rst) |-> !bit_strobe_o && !early_o && !late_o && !locked_o);
    a_r6_not_both: assert property (@(posedge clk) disable iff (rst)
        !(early_o && late_o));

endmodule

// File: tb/cell_clock_recover_bench.sv
module cell_clock_recover_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line = 1'b0;
    logic strobe, locked, early, late;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    byte exp_q[$];
    int  pulses = 0;

    int  since = 1;
    bit  short_armed = 1'b0, late_seen = 1'b0, early_seen = 1'b0;
    int  pulses_in_period = 0;
    bit  first_strobe = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cell_clock_recover u_cell_clock_recover (
        .clk          (clk),
        .rst          (rst),
        .line_i       (line),
        .bit_strobe_o (strobe),
        .locked_o     (locked),
        .early_o      (early),
        .late_o       (late)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: one coded cell of len clocks, mid-cell change for a one.
    task automatic send_cell(input int len, input bit one);
        line <= ~line;
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            if (one && i == len / 2) line <= ~line;
        end
        @(negedge clk);
    endtask

    function automatic bit pat(input int k);
        return ((k * 5 + 3) % 7) < 3;
    endfunction

    // Monitor: scoreboard of correction pulses and strobe spacing.
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                since = 1;
            end else begin
                since++;
                if (early || late) begin
                    pulses++;
                    chk(pulses_in_period == 0, "R6", "second pulse in one period",
                        pulses_in_period + 1, 1);
                    pulses_in_period++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7", "unexpected correction pulse (late=1/early=0)",
                            int'(late), -1);
                    end else begin
                        byte e;
                        e = exp_q.pop_front();
                        if (e == "L")
                            chk(late && !early, "R4", "late pulse expected", int'(late), 1);
                        else
                            chk(early && !late, "R5", "early pulse expected", int'(early), 1);
                    end
                    if (late) late_seen = 1'b1;
                    if (early) early_seen = 1'b1;
                end
                if (strobe) begin
                    int expv;
                    expv = short_armed ? 7 : (late_seen ? 9 : 8);
                    if (first_strobe)
                        chk(since == 8, "R1", "first strobe position", since, 8);
                    else if (expv == 7)
                        chk(since == expv, "R5", "shortened period length", since, expv);
                    else if (expv == 9)
                        chk(since == expv, "R4", "stretched period length", since, expv);
                    else
                        chk(since == expv, "R2", "nominal period length", since, expv);
                    first_strobe = 1'b0;
                    short_armed = early_seen;
                    late_seen = 1'b0;
                    early_seen = 1'b0;
                    pulses_in_period = 0;
                    since = 0;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run incomplete actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p0;
        repeat (3) begin
            @(negedge clk);
            chk(!strobe && !early && !late && !locked, "R1", "outputs during reset",
                int'({strobe, early, late, locked}), 0);
        end
        @(negedge clk);
        rst <= 1'b0;

        // Align the first coded edge with count 0 (R3: two-cycle detection lag).
        do @(negedge clk); while (!strobe);
        repeat (7) @(negedge clk);

        for (int k = 0; k < 16; k++) send_cell(8, pat(k));
        chk(pulses == 0, "R3", "pulses on aligned mixed stream", pulses, 0);
        chk(!locked, "R8", "lock before sixteen clean periods", int'(locked), 0);
        send_cell(8, pat(16));
        chk(locked, "R8", "lock after sixteen clean periods", int'(locked), 1);

        // Single early step, then single late step, while locked.
        exp_q.push_back("E");
        send_cell(7, 1'b1);
        for (int k = 0; k < 6; k++) send_cell(8, pat(k));
        exp_q.push_back("L");
        send_cell(9, 1'b1);
        for (int k = 0; k < 6; k++) send_cell(8, pat(k + 3));
        chk(locked, "R9", "isolated corrections keep lock", int'(locked), 1);
        chk(exp_q.size() == 0, "R4", "step pulses delivered", exp_q.size(), 0);

        // Three-count step into the mid-cell zone and back.
        p0 = pulses;
        send_cell(11, 1'b0);
        for (int k = 0; k < 6; k++) send_cell(8, 1'b0);
        send_cell(5, 1'b0);
        for (int k = 0; k < 4; k++) send_cell(8, 1'b0);
        chk(pulses == p0, "R7", "mid-zone edges ignored", pulses - p0, 0);
        chk(locked, "R7", "lock unaffected by mid-zone step", int'(locked), 1);

        // Fast source: four early corrections in a row.
        repeat (4) exp_q.push_back("E");
        for (int k = 0; k < 4; k++) send_cell(7, 1'b0);
        chk(locked, "R9", "lock held after three early runs", int'(locked), 1);
        send_cell(8, 1'b0);
        chk(!locked, "R9", "lock lost after four early runs", int'(locked), 0);

        for (int k = 0; k < 20; k++) send_cell(8, pat(k));
        chk(locked, "R8", "relock after clean stream", int'(locked), 1);

        // Slow source: late corrections every period.
        repeat (5) exp_q.push_back("L");
        for (int k = 0; k < 5; k++) send_cell(9, 1'b0);
        send_cell(8, 1'b0);
        chk(!locked, "R9", "lock lost on slow source", int'(locked), 0);
        for (int k = 0; k < 4; k++) send_cell(8, 1'b0);
        chk(exp_q.size() == 0, "R5", "all expected pulses seen", exp_q.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule